// File: doc/BRIEF.md
# USB Endpoint Bank Status Tracker

This block keeps the bookkeeping for a USB device endpoint whose packet buffer is split into one, two or three banks. The endpoint is set up either to send data to the host (IN) or to receive data from it (OUT). Two agents move banks around the ring. Firmware issues a single strobe that means "bank filled" on an IN endpoint and "bank released" on an OUT endpoint. The serial engine issues a transaction-done strobe, which carries the acknowledge result, the received data toggle and a short-packet indication.

From these strobes the tracker reports several values. It gives the bank the firmware should touch next and the number of busy banks. It gives the data toggle, which is the next toggle to send on IN and the toggle last received into the current bank on OUT. It also gives a sticky short-packet flag and an endpoint interrupt. The interrupt fires on "all free" for IN and on "all busy" for OUT.

Firmware strobes take effect after a fixed delay of two clock cycles, matching the address computation in a larger buffer controller. Engine strobes take effect on the next clock edge. Configuration inputs are held stable outside reset.

Top module: `usb_ep_bank_tracker`

## Requirements
- R1: `cur_bank` names the firmware's bank with code 0, 1 or 2. It steps 0→1→2→0, wrapping at the configured bank count (a `cfg_nbanks` of 0 or 1 means one bank). It never shows code 3 or a bank at or above the configured count.
- R2: On IN, an accepted firmware strobe adds one to `busy_cnt` and an acknowledged engine transaction removes one. A firmware strobe with all banks busy is ignored, and so is an acknowledged transaction with zero busy. An unacknowledged transaction changes nothing.
- R3: On OUT, an engine transaction adds one to `busy_cnt` and a firmware strobe removes one. A transaction arriving with all banks busy is ignored, including its toggle. A firmware strobe arriving with zero busy is ignored.
- R4: `ep_irq` is high only when `busy_ie` is 1. On IN it asserts when `busy_cnt` is 0, and on OUT it asserts when `busy_cnt` equals the configured bank count.
- R5: `dtseq` reads 2'b00 for DATA0 and 2'b01 for DATA1. It resets to 2'b01, and its upper bit is always 0.
- R6: On IN, `dtseq` inverts on each accepted, acknowledged transaction and on nothing else, whichever bank is current.
- R7: On OUT, each accepted transaction records `eng_data1` against the bank it filled. `dtseq` shows the record of the bank named by `cur_bank`.
- R8: An accepted firmware strobe changes `busy_cnt` and `cur_bank` on the second rising edge after the edge that sampled it. A firmware strobe sampled while an earlier one is still in flight is ignored. Engine strobes change `busy_cnt` on the next edge.
- R9: `short_pkt` sets when an accepted OUT transaction on a non-control endpoint (`cfg_control` = 0) reports `eng_short`. `short_clr` clears it, and a set in the same cycle wins. It never sets on IN or control endpoints.
- R10: While `rst_n` is low at a rising edge, all state returns to its defaults: bank 0, zero busy, toggle 2'b01, short flag clear, nothing in flight.
- R11: A firmware strobe that lands in the same cycle as an engine transaction has both effects applied to `busy_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_nbanks | input | 2 | Configured bank count (0 and 1 both mean one bank, 3 is the most) |
| cfg_control | input | 1 | Endpoint is a control endpoint |
| busy_ie | input | 1 | Enable for the busy-bank interrupt |
| fw_bank_done | input | 1 | Firmware strobe: bank filled (IN) or released (OUT) |
| eng_txn_done | input | 1 | Engine strobe: transaction finished |
| eng_ack | input | 1 | IN transaction was acknowledged by the host |
| eng_data1 | input | 1 | Received PID was DATA1 (OUT) |
| eng_short | input | 1 | Received packet was shorter than the maximum size |
| short_clr | input | 1 | Write-one-to-clear for the short flag |
| cur_bank | output | 2 | Firmware's current bank index |
| busy_cnt | output | 2 | Number of busy banks |
| dtseq | output | 2 | Data toggle field |
| short_pkt | output | 1 | Short packet received |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
The OUT sequence fills a three-bank ring to full with alternating toggles and short indications. It shows that an overflowing transaction drops its toggle and that `dtseq` follows `cur_bank` rather than the engine's pointer. It also shows that a release and a fill in the same window net to zero. The IN sequence holds the firmware strobe for two cycles, which separates "one fill" from "two fills", and samples between the strobe and the second edge to pin the latency. It also mixes acknowledged and unacknowledged transactions, so toggle flips can be told apart from bank moves. Single-bank, two-bank, control-endpoint and interrupt-disabled runs cover the wrap points and the qualifiers on the flags.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    localparam int EP_MAX_BANKS = 3;
    localparam int EP_PTR_W     = (EP_MAX_BANKS > 1) ? $clog2(EP_MAX_BANKS) : 1;
    localparam int EP_CNT_W     = $clog2(EP_MAX_BANKS + 1);
    localparam int EP_TOG_W     = 2;

    // Registered state of one endpoint
    typedef struct packed {
        logic [EP_PTR_W-1:0]     fw_ptr;      // bank firmware works on
        logic [EP_PTR_W-1:0]     eng_ptr;     // bank the engine works on
        logic [EP_CNT_W-1:0]     cnt;         // busy banks
        logic                    in_tog;      // next IN toggle (1 = DATA1)
        logic [EP_MAX_BANKS-1:0] out_tog;     // last OUT toggle per bank
        logic                    short_flag;
    } ep_state_t;

    localparam ep_state_t EP_STATE_RESET = '{
        fw_ptr:     '0,
        eng_ptr:    '0,
        cnt:        '0,
        in_tog:     1'b1,
        out_tog:    '1,
        short_flag: 1'b0
    };

endpackage

// File: rtl/ep_ring_step.sv
module ep_ring_step
    import usb_ep_pkg::*;
(
    input  logic [EP_PTR_W-1:0] ptr_i,
    input  logic [EP_CNT_W-1:0] nbanks_i,
    output logic [EP_PTR_W-1:0] ptr_o
);

    logic [EP_CNT_W-1:0] after_d;

    always_comb begin
        after_d = EP_CNT_W'(ptr_i) + EP_CNT_W'(1);
        if (after_d >= nbanks_i) begin
            ptr_o = '0;
        end else begin
            ptr_o = ptr_i + EP_PTR_W'(1);
        end
    end

endmodule

// File: rtl/ep_event_delay.sv
module ep_event_delay #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic busy_o,
    output logic evt_o
);

    localparam int STAGES = (LAT < 1) ? 1 : LAT;

    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = evt_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign busy_o = |stg_q;
    assign evt_o  = stg_q[STAGES-1];

endmodule

// File: rtl/usb_ep_bank_tracker.sv
module usb_ep_bank_tracker
    import usb_ep_pkg::*;
#(
    parameter int FW_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_dir_in,
    input  logic [EP_CNT_W-1:0] cfg_nbanks,
    input  logic                cfg_control,
    input  logic                busy_ie,
    input  logic                fw_bank_done,
    input  logic                eng_txn_done,
    input  logic                eng_ack,
    input  logic                eng_data1,
    input  logic                eng_short,
    input  logic                short_clr,
    output logic [EP_PTR_W-1:0] cur_bank,
    output logic [EP_CNT_W-1:0] busy_cnt,
    output logic [EP_TOG_W-1:0] dtseq,
    output logic                short_pkt,
    output logic                ep_irq
);

    localparam int N_PTRS = 2;   // 0: firmware side, 1: engine side

    ep_state_t           st_d, st_q;
    logic [EP_CNT_W-1:0] nb_eff;
    logic                fw_room, fw_acc, fw_pend, fw_fire;
    logic                eng_room, eng_acc;
    logic                cnt_up, cnt_dn;
    logic                tog_sel;
    logic [EP_PTR_W-1:0] ptr_cur [N_PTRS];
    logic [EP_PTR_W-1:0] ptr_nxt [N_PTRS];

    // Effective bank count: clamp to 1..EP_MAX_BANKS
    always_comb begin
        if (cfg_nbanks == '0) begin
            nb_eff = EP_CNT_W'(1);
        end else if (cfg_nbanks > EP_CNT_W'(EP_MAX_BANKS)) begin
            nb_eff = EP_CNT_W'(EP_MAX_BANKS);
        end else begin
            nb_eff = cfg_nbanks;
        end
    end

    assign ptr_cur[0] = st_q.fw_ptr;
    assign ptr_cur[1] = st_q.eng_ptr;

    generate
        for (genvar g = 0; g < N_PTRS; g++) begin : g_step
            ep_ring_step u_step (
                .ptr_i    (ptr_cur[g]),
                .nbanks_i (nb_eff),
                .ptr_o    (ptr_nxt[g])
            );
        end
    endgenerate

    // Firmware strobes travel through a fixed delay before they count
    ep_event_delay #(.LAT(FW_LAT)) u_fw_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (fw_acc),
        .busy_o (fw_pend),
        .evt_o  (fw_fire)
    );

    // Acceptance: firmware needs a free bank (IN) or a busy one (OUT);
    // the engine needs a busy bank and an ACK (IN) or a free bank (OUT)
    always_comb begin
        fw_room  = cfg_dir_in ? (st_q.cnt < nb_eff) : (st_q.cnt != '0);
        fw_acc   = rst_n & fw_bank_done & ~fw_pend & fw_room;
        eng_room = cfg_dir_in ? (eng_ack & (st_q.cnt != '0))
                              : (st_q.cnt < nb_eff);
        eng_acc  = rst_n & eng_txn_done & eng_room;
        cnt_up   = cfg_dir_in ? fw_fire : eng_acc;
        cnt_dn   = cfg_dir_in ? eng_acc : fw_fire;
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;

        if (fw_fire) begin
            st_d.fw_ptr = ptr_nxt[0];
        end
        if (eng_acc) begin
            st_d.eng_ptr = ptr_nxt[1];
        end

        unique case ({cnt_up, cnt_dn})
            2'b10:   st_d.cnt = st_q.cnt + EP_CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - EP_CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase

        if (eng_acc && cfg_dir_in) begin
            st_d.in_tog = ~st_q.in_tog;
        end

        if (eng_acc && !cfg_dir_in) begin
            for (int i = 0; i < EP_MAX_BANKS; i++) begin
                if (st_q.eng_ptr == EP_PTR_W'(i)) begin
                    st_d.out_tog[i] = eng_data1;
                end
            end
        end

        if (eng_acc && !cfg_dir_in && !cfg_control && eng_short) begin
            st_d.short_flag = 1'b1;
        end else if (short_clr) begin
            st_d.short_flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= EP_STATE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs
    always_comb begin
        tog_sel = 1'b0;
        for (int i = 0; i < EP_MAX_BANKS; i++) begin
            if (st_q.fw_ptr == EP_PTR_W'(i)) begin
                tog_sel = st_q.out_tog[i];
            end
        end
    end

    assign cur_bank  = st_q.fw_ptr;
    assign busy_cnt  = st_q.cnt;
    assign dtseq     = {{(EP_TOG_W-1){1'b0}}, (cfg_dir_in ? st_q.in_tog : tog_sel)};
    assign short_pkt = st_q.short_flag;
    assign ep_irq    = busy_ie & (cfg_dir_in ? (st_q.cnt == '0) : (st_q.cnt == nb_eff));

endmodule

// File: rtl/ep_tracker_checker.sv
module ep_tracker_checker
    import usb_ep_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_dir_in,
    input logic                cfg_control,
    input logic [EP_CNT_W-1:0] nb_eff,
    input logic [EP_PTR_W-1:0] cur_bank,
    input logic [EP_CNT_W-1:0] busy_cnt,
    input logic [EP_TOG_W-1:0] dtseq,
    input logic                short_pkt,
    input logic                eng_txn_done,
    input logic                fw_fire
);

    // R1: bank index stays below the configured count
    a_r1_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        EP_CNT_W'(cur_bank) < nb_eff);

    // R2 / R3: busy count never exceeds the bank count
    a_r2_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= nb_eff);

    // R5: only DATA0/DATA1 codes appear
    a_r5_toggle_code: assert property (@(posedge clk) disable iff (!rst_n)
        dtseq[EP_TOG_W-1] == 1'b0);

    // R6: IN toggle moves only after an engine transaction
    a_r6_in_toggle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && !$past(eng_txn_done)) |-> $stable(dtseq));

    // R8: a delayed firmware event moves the bank on multi-bank rings
    a_r8_bank_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fw_fire) && nb_eff > EP_CNT_W'(1)) |-> (cur_bank != $past(cur_bank)));

    // R8: without a delayed firmware event the bank holds
    a_r8_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fw_fire) |-> $stable(cur_bank));

    // R9: control endpoints never flag short packets
    a_r9_no_short_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_control |-> !short_pkt);

endmodule

bind usb_ep_bank_tracker ep_tracker_checker i_ep_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dir_in   (cfg_dir_in),
    .cfg_control  (cfg_control),
    .nb_eff       (nb_eff),
    .cur_bank     (cur_bank),
    .busy_cnt     (busy_cnt),
    .dtseq        (dtseq),
    .short_pkt    (short_pkt),
    .eng_txn_done (eng_txn_done),
    .fw_fire      (fw_fire)
);

// File: tb/test_usb_ep_bank_tracker.sv
`timescale 1ns/1ps
module test_usb_ep_bank_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_dir_in = 1'b0;
    logic [1:0] cfg_nbanks = 2'd3;
    logic       cfg_control = 1'b0;
    logic       busy_ie = 1'b1;
    logic       fw_bank_done = 1'b0;
    logic       eng_txn_done = 1'b0;
    logic       eng_ack = 1'b0;
    logic       eng_data1 = 1'b0;
    logic       eng_short = 1'b0;
    logic       short_clr = 1'b0;
    logic [1:0] cur_bank;
    logic [1:0] busy_cnt;
    logic [1:0] dtseq;
    logic       short_pkt;
    logic       ep_irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    usb_ep_bank_tracker i_usb_ep_bank_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_dir_in   (cfg_dir_in),
        .cfg_nbanks   (cfg_nbanks),
        .cfg_control  (cfg_control),
        .busy_ie      (busy_ie),
        .fw_bank_done (fw_bank_done),
        .eng_txn_done (eng_txn_done),
        .eng_ack      (eng_ack),
        .eng_data1    (eng_data1),
        .eng_short    (eng_short),
        .short_clr    (short_clr),
        .cur_bank     (cur_bank),
        .busy_cnt     (busy_cnt),
        .dtseq        (dtseq),
        .short_pkt    (short_pkt),
        .ep_irq       (ep_irq)
    );

    // OUT endpoint, three banks, interrupt enabled.
    // {fw, eng, pid1, short, clr} _ cnt _ bank _ dtseq _ {short_pkt, irq}
    localparam int NVEC = 11;
    localparam logic [12:0] VEC [NVEC] = '{
        13'b01000_01_00_00_00,  // fill bank0 with DATA0
        13'b01110_10_00_00_10,  // fill bank1 with DATA1, short
        13'b01000_11_00_00_11,  // fill bank2, all busy
        13'b01100_11_00_00_11,  // overflow ignored
        13'b00001_11_00_00_01,  // clear short
        13'b10000_10_01_01_00,  // release bank0
        13'b11100_10_10_00_00,  // release + fill together
        13'b10000_01_00_01_00,  // release bank2 (wrap)
        13'b10000_00_01_01_00,  // release bank0
        13'b10000_00_01_01_00,  // release with none busy ignored
        13'b01011_01_01_00_10   // fill with short and clear together
    };

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input int c, input int b,
                           input int d, input int s, input int q);
        chk(req, "busy_cnt", int'(busy_cnt), c);
        chk(req, "cur_bank", int'(cur_bank), b);
        chk(req, "dtseq", int'(dtseq), d);
        chk(req, "short_pkt", int'(short_pkt), s);
        chk(req, "ep_irq", int'(ep_irq), q);
    endtask

    task automatic do_reset(input logic dir, input logic [1:0] nb,
                            input logic ctrl, input logic ie);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_dir_in = dir;
        cfg_nbanks = nb;
        cfg_control = ctrl;
        busy_ie = ie;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Firmware pulse, then wait until it has landed
    task automatic fw_pulse();
        fw_bank_done = 1'b1;
        @(negedge clk);
        fw_bank_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic eng_pulse(input logic ack, input logic pid1, input logic shrt);
        eng_txn_done = 1'b1;
        eng_ack = ack;
        eng_data1 = pid1;
        eng_short = shrt;
        @(negedge clk);
        eng_txn_done = 1'b0;
        eng_ack = 1'b0;
        eng_data1 = 1'b0;
        eng_short = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // ---- Vector walk: OUT, 3 banks (R3 R7 R9 R11 R1 R4) ----
        do_reset(1'b0, 2'd3, 1'b0, 1'b1);
        chk_all("R10 reset OUT", 0, 0, 1, 0, 0);
        for (int v = 0; v < NVEC; v++) begin
            fw_bank_done = VEC[v][12];
            eng_txn_done = VEC[v][11];
            eng_data1    = VEC[v][10];
            eng_short    = VEC[v][9];
            short_clr    = VEC[v][8];
            @(negedge clk);
            fw_bank_done = 1'b0;
            eng_txn_done = 1'b0;
            eng_data1    = 1'b0;
            eng_short    = 1'b0;
            short_clr    = 1'b0;
            repeat (2) @(negedge clk);
            chk_all($sformatf("R3/R7/R9/R11 vec%0d", v), int'(VEC[v][7:6]), int'(VEC[v][5:4]),
                    int'(VEC[v][3:2]), int'(VEC[v][1]), int'(VEC[v][0]));
        end

        // ---- OUT engine latency of one cycle (R8) ----
        do_reset(1'b0, 2'd3, 1'b0, 1'b1);
        eng_pulse(1'b0, 1'b0, 1'b0);
        chk("R8 engine next edge", "busy_cnt", int'(busy_cnt), 1);

        // ---- IN, 3 banks, interrupt enabled ----
        do_reset(1'b1, 2'd3, 1'b0, 1'b1);
        chk_all("R10 reset IN", 0, 0, 1, 0, 1);
        // strobe held two cycles: only one fill, two-cycle latency
        fw_bank_done = 1'b1;
        @(negedge clk);
        chk("R8 before landing 1", "busy_cnt", int'(busy_cnt), 0);
        @(negedge clk);
        fw_bank_done = 1'b0;
        chk("R8 before landing 2", "cur_bank", int'(cur_bank), 0);
        @(negedge clk);
        chk("R8 landed", "busy_cnt", int'(busy_cnt), 1);
        chk("R8 landed", "cur_bank", int'(cur_bank), 1);
        repeat (2) @(negedge clk);
        chk("R8 held strobe counted once", "busy_cnt", int'(busy_cnt), 1);
        chk("R4 IN not empty", "ep_irq", int'(ep_irq), 0);
        fw_pulse();
        fw_pulse();
        chk("R1 wrap at three", "cur_bank", int'(cur_bank), 0);
        chk("R2 full", "busy_cnt", int'(busy_cnt), 3);
        fw_pulse();
        chk("R2 fill when full ignored", "busy_cnt", int'(busy_cnt), 3);
        chk("R2 fill when full ignored", "cur_bank", int'(cur_bank), 0);
        eng_pulse(1'b0, 1'b0, 1'b0);
        chk("R6 no ack no flip", "dtseq", int'(dtseq), 1);
        chk("R2 no ack keeps count", "busy_cnt", int'(busy_cnt), 3);
        eng_pulse(1'b1, 1'b0, 1'b1);
        chk("R6 ack flips", "dtseq", int'(dtseq), 0);
        chk("R2 ack sends bank", "busy_cnt", int'(busy_cnt), 2);
        chk("R9 IN short ignored", "short_pkt", int'(short_pkt), 0);
        eng_pulse(1'b1, 1'b0, 1'b0);
        eng_pulse(1'b1, 1'b0, 1'b0);
        chk("R6 two more flips", "dtseq", int'(dtseq), 0);
        chk_all("R4 IN empty irq", 0, 0, 0, 0, 1);
        eng_pulse(1'b1, 1'b0, 1'b0);
        chk("R6 ack when empty ignored", "dtseq", int'(dtseq), 0);
        chk("R2 ack when empty ignored", "busy_cnt", int'(busy_cnt), 0);

        // ---- Reset mid-operation (R10) ----
        fw_pulse();
        do_reset(1'b1, 2'd3, 1'b0, 1'b1);
        chk_all("R10 reset after use", 0, 0, 1, 0, 1);

        // ---- IN, 2 banks, interrupt disabled ----
        do_reset(1'b1, 2'd2, 1'b0, 1'b0);
        chk("R4 disabled irq", "ep_irq", int'(ep_irq), 0);
        fw_pulse();
        fw_pulse();
        chk("R1 wrap at two", "cur_bank", int'(cur_bank), 0);
        chk("R2 two-bank full", "busy_cnt", int'(busy_cnt), 2);

        // ---- OUT, 1 bank, control endpoint ----
        do_reset(1'b0, 2'd1, 1'b1, 1'b1);
        eng_pulse(1'b0, 1'b1, 1'b1);
        chk_all("R9 control no short / R4 OUT full", 1, 0, 1, 0, 1);
        fw_pulse();
        chk_all("R1 single bank stays 0", 0, 0, 1, 0, 0);

        // ---- bank count 0 behaves as one bank ----
        do_reset(1'b0, 2'd0, 1'b0, 1'b1);
        eng_pulse(1'b0, 1'b0, 1'b0);
        eng_pulse(1'b0, 1'b1, 1'b0);
        chk_all("R1 zero means one bank", 1, 0, 0, 0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule